// File: doc/BRIEF.md
# Lockable Register File with Potentiometer Wiper Outputs

This block is a 256-byte register file behind a plain synchronous byte port: an address, write data, a write strobe and registered read data. Two bytes near the top of the map set two digital potentiometer wipers. Wiper A has 256 positions and follows its setting byte directly. Wiper B has 100 positions. Its setting byte loses its top bit, and any remaining value past the last tap is clamped to that tap.

A lock byte guards three address regions. The region covering the top of the map also covers the lock byte itself. Once that top lock is set, the protection cannot be changed again until reset. Every write strobe produces a one-cycle verdict: accepted or refused. The reset state stands in for recall from nonvolatile storage, so all bytes are zero and nothing is locked.

Top module: `wp_regmem`

## Requirements
- R1: After reset, every address reads 00h, both wiper outputs are 0, no lock bit is set, and both write flags are low.
- R2: Read data is registered. `rd_data` shows the byte at the address presented on the previous clock edge, at any address and under any lock state. Addresses FBh–FFh read as 00h.
- R3: While unlocked, a write to any user address 00h–F7h stores the byte, and a later read returns it.
- R4: `wiper_a` equals the byte stored at F8h, over the full range 00h–FFh.
- R5: `wiper_b` is the byte stored at F9h with bit 7 discarded, clamped to at most 63h (99). A read of F9h returns the full byte as written.
- R6: The lock byte sits at FAh and keeps only bits 2:0. A read of FAh returns {5'b0, lock bits}.
- R7: When lock bit 0 is set, writes to 00h–7Fh are refused. When lock bit 1 is set, writes to 80h–F7h are refused. A refused write changes no byte.
- R8: When lock bit 2 is set, writes to F8h–FFh are refused. This includes the lock byte, so all lock bits stay frozen until reset, and both wipers hold.
- R9: Writes to the reserved addresses FBh–FFh are always refused and change no state.
- R10: One clock after a write strobe, exactly one of `wr_ok` and `wr_rej` is high for one cycle. Without a strobe, both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte address for reads and writes |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_data | output | 8 | Registered read data |
| wiper_a | output | 8 | 256-position wiper setting |
| wiper_b | output | 7 | 100-position wiper setting, 0 to 99 |
| wr_ok | output | 1 | Previous-cycle write was accepted |
| wr_rej | output | 1 | Previous-cycle write was refused |

## Verification
The assertions assume that `addr`, `wdata` and `wr_en` are settled and known at each rising edge, and that `wr_en` is held low while reset is asserted. The stimulus meets this by changing inputs only on falling edges and by lowering the strobe before every reset. The bench keeps a byte-level model of the map and the lock bits. It sweeps every address and every value of both wiper bytes, and it walks the lock combinations, including the frozen state, to cover each accept and refuse path.

// File: rtl/wp_mem_pkg.sv
package wp_mem_pkg;

    localparam int AW     = 8;
    localparam int DW     = 8;
    localparam int DEPTH  = 1 << AW;
    localparam int LOCK_W = 3;
    localparam int WIPB_POS = 100;
    localparam int WIPB_W = $clog2(WIPB_POS);

    localparam logic [AW-1:0] LOW_TOP   = 8'h7F;
    localparam logic [AW-1:0] USER_TOP  = 8'hF7;
    localparam logic [AW-1:0] WIPA_ADDR = 8'hF8;
    localparam logic [AW-1:0] WIPB_ADDR = 8'hF9;
    localparam logic [AW-1:0] LOCK_ADDR = 8'hFA;

    // lock bit positions
    localparam int LK_LOW  = 0;
    localparam int LK_HIGH = 1;
    localparam int LK_TOP  = 2;

    typedef enum logic [2:0] {
        RG_LOW,
        RG_HIGH,
        RG_WIPER,
        RG_LOCK,
        RG_RSVD
    } region_e;

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } wr_req_t;

    typedef struct packed {
        logic ok;
        logic rej;
    } wr_verdict_t;

    function automatic logic [WIPB_W-1:0] clamp_wipb(input logic [DW-1:0] v);
        logic [DW-2:0] low;
        low = v[DW-2:0];
        if (int'(low) > WIPB_POS - 1)
            return WIPB_W'(WIPB_POS - 1);
        return low[WIPB_W-1:0];
    endfunction

endpackage

// File: rtl/wp_region_decode.sv
module wp_region_decode
    import wp_mem_pkg::*;
#(
    parameter int A_W = AW
) (
    input  logic [A_W-1:0] addr,
    output region_e        region
);
    always_comb begin
        if (addr <= LOW_TOP)
            region = RG_LOW;
        else if (addr <= USER_TOP)
            region = RG_HIGH;
        else if (addr == WIPA_ADDR || addr == WIPB_ADDR)
            region = RG_WIPER;
        else if (addr == LOCK_ADDR)
            region = RG_LOCK;
        else
            region = RG_RSVD;
    end
endmodule

// File: rtl/wp_lock_ctrl.sv
module wp_lock_ctrl
    import wp_mem_pkg::*;
#(
    parameter int L_W = LOCK_W
) (
    input  logic           clk,
    input  logic           rst,
    input  wr_req_t        req,
    input  region_e        region,
    output logic [L_W-1:0] lock_q,
    output logic           accept,
    output wr_verdict_t    verdict
);
    logic permitted;

    always_comb begin
        unique case (region)
            RG_LOW:   permitted = !lock_q[LK_LOW];
            RG_HIGH:  permitted = !lock_q[LK_HIGH];
            RG_WIPER: permitted = !lock_q[LK_TOP];
            RG_LOCK:  permitted = !lock_q[LK_TOP];
            default:  permitted = 1'b0;
        endcase
        accept = req.vld && permitted;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q  <= '0;
            verdict <= '0;
        end else begin
            if (accept && region == RG_LOCK)
                lock_q <= req.data[L_W-1:0];
            verdict.ok  <= accept;
            verdict.rej <= req.vld && !accept;
        end
    end
endmodule

// File: rtl/wp_store.sv
module wp_store
    import wp_mem_pkg::*;
#(
    parameter int A_W = AW,
    parameter int D_W = DW,
    parameter int N   = DEPTH
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [A_W-1:0] addr,
    input  logic [D_W-1:0] wdata,
    output logic [D_W-1:0] rd_byte,
    output logic [D_W-1:0] wipa_byte,
    output logic [D_W-1:0] wipb_byte
);
    logic [D_W-1:0] mem [N];

    for (genvar i = 0; i < N; i++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '0;
            else if (we && addr == A_W'(i))
                mem[i] <= wdata;
        end
    end

    assign rd_byte   = mem[addr];
    assign wipa_byte = mem[WIPA_ADDR];
    assign wipb_byte = mem[WIPB_ADDR];
endmodule

// File: rtl/wp_wiper_map.sv
module wp_wiper_map
    import wp_mem_pkg::*;
#(
    parameter int D_W  = DW,
    parameter int B_W  = WIPB_W
) (
    input  logic [D_W-1:0] wipa_byte,
    input  logic [D_W-1:0] wipb_byte,
    output logic [D_W-1:0] wiper_a,
    output logic [B_W-1:0] wiper_b
);
    assign wiper_a = wipa_byte;
    assign wiper_b = clamp_wipb(wipb_byte);
endmodule

// File: rtl/wp_regmem.sv
module wp_regmem
    import wp_mem_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          wr_en,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] wiper_a,
    output logic [WIPB_W-1:0] wiper_b,
    output logic          wr_ok,
    output logic          wr_rej
);
    wr_req_t        req;
    region_e        region;
    logic [LOCK_W-1:0] lock_q;
    logic           accept;
    wr_verdict_t    verdict;
    logic           store_we;
    logic [DW-1:0]  mem_byte, wipa_byte, wipb_byte, rd_next;

    assign req = '{vld: wr_en, addr: addr, data: wdata};

    wp_region_decode u_dec (
        .addr   (addr),
        .region (region)
    );

    wp_lock_ctrl u_lock (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .region  (region),
        .lock_q  (lock_q),
        .accept  (accept),
        .verdict (verdict)
    );

    assign store_we = accept &&
                      (region == RG_LOW || region == RG_HIGH || region == RG_WIPER);

    wp_store u_store (
        .clk       (clk),
        .rst       (rst),
        .we        (store_we),
        .addr      (addr),
        .wdata     (wdata),
        .rd_byte   (mem_byte),
        .wipa_byte (wipa_byte),
        .wipb_byte (wipb_byte)
    );

    wp_wiper_map u_wip (
        .wipa_byte (wipa_byte),
        .wipb_byte (wipb_byte),
        .wiper_a   (wiper_a),
        .wiper_b   (wiper_b)
    );

    always_comb begin
        unique case (region)
            RG_LOCK: rd_next = {{(DW-LOCK_W){1'b0}}, lock_q};
            RG_RSVD: rd_next = '0;
            default: rd_next = mem_byte;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rd_data <= '0;
        else     rd_data <= rd_next;
    end

    assign wr_ok  = verdict.ok;
    assign wr_rej = verdict.rej;
endmodule

// File: rtl/wp_regmem_chk.sv
module wp_regmem_chk
    import wp_mem_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [AW-1:0]     addr,
    input logic              wr_en,
    input logic [DW-1:0]     wiper_a,
    input logic [WIPB_W-1:0] wiper_b,
    input logic              wr_ok,
    input logic              wr_rej,
    input logic [LOCK_W-1:0] lock_q
);
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(wr_ok && wr_rej)); // R10
    AST_FLAG_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> !wr_ok && !wr_rej); // R10
    AST_WIPB_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(wiper_b) <= WIPB_POS - 1); // R5
    AST_RSVD_REFUSED: assert property (@(posedge clk) disable iff (rst)
        wr_en && addr > LOCK_ADDR |=> wr_rej); // R9
    AST_TOP_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        wr_en && addr >= WIPA_ADDR && lock_q[LK_TOP]
        |=> wr_rej && $stable(wiper_a) && $stable(wiper_b) && $stable(lock_q)); // R8
    AST_LOW_LOCK_REFUSES: assert property (@(posedge clk) disable iff (rst)
        wr_en && addr <= LOW_TOP && lock_q[LK_LOW] |=> wr_rej); // R7
    AST_HIGH_LOCK_REFUSES: assert property (@(posedge clk) disable iff (rst)
        wr_en && addr > LOW_TOP && addr <= USER_TOP && lock_q[LK_HIGH] |=> wr_rej); // R7
    AST_USER_OPEN_ACCEPTS: assert property (@(posedge clk) disable iff (rst)
        wr_en && addr <= LOW_TOP && !lock_q[LK_LOW] |=> wr_ok); // R3
endmodule

bind wp_regmem wp_regmem_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_en   (wr_en),
    .wiper_a (wiper_a),
    .wiper_b (wiper_b),
    .wr_ok   (wr_ok),
    .wr_rej  (wr_rej),
    .lock_q  (lock_q)
);

// File: tb/sim_wp_regmem.sv
module sim_wp_regmem;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic [7:0] rd_data, wiper_a;
    logic [6:0] wiper_b;
    logic       wr_ok, wr_rej;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0] mem_m [256];
    logic [2:0] lock_m;

    always #2 clk = ~clk;

    wp_regmem u0 (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_data(rd_data), .wiper_a(wiper_a), .wiper_b(wiper_b),
        .wr_ok(wr_ok), .wr_rej(wr_rej)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic int exp_wipb(input logic [7:0] v);
        int low = v & 8'h7F;
        return (low > 99) ? 99 : low;
    endfunction

    function automatic bit may_write(input logic [7:0] a);
        if (a >= 8'hFB) return 0;
        if (a >= 8'hF8) return !lock_m[2];
        if (a >= 8'h80) return !lock_m[1];
        return !lock_m[0];
    endfunction

    task automatic do_reset();
        @(negedge clk);
        wr_en = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;
        lock_m = 3'b000;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
        bit acc;
        acc = may_write(a);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1;
        @(posedge clk);
        #1;
        wr_en = 0;
        if (acc) begin
            if (a == 8'hFA) lock_m = d[2:0];
            else mem_m[a] = d;
        end
        check({tag, " R10 ok"}, wr_ok, acc);
        check({tag, " R10 rej"}, wr_rej, !acc);
        check({tag, " R4 wiper_a"}, wiper_a, mem_m[8'hF8]);
        check({tag, " R5 wiper_b"}, wiper_b, exp_wipb(mem_m[8'hF9]));
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        int exp;
        exp = (a == 8'hFA) ? int'(lock_m) : (a >= 8'hFB) ? 0 : int'(mem_m[a]);
        @(negedge clk);
        addr = a; wr_en = 0;
        @(posedge clk);
        #1;
        check({tag, " R2 rd"}, rd_data, exp);
        check({tag, " R10 idle"}, {wr_ok, wr_rej}, 0);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state over the whole map
        check("R1 wiper_a", wiper_a, 0);
        check("R1 wiper_b", wiper_b, 0);
        check("R1 flags", {wr_ok, wr_rej}, 0);
        for (int a = 0; a < 256; a++) rd(8'(a), "R1");

        // R3: fill user space and wiper bytes, then read all back
        for (int a = 0; a < 8'hFA; a++) wr(8'(a), 8'(a ^ 8'h5A), "R3 fill");
        for (int a = 0; a < 256; a++) rd(8'(a), "R3 readback");

        // R4 and R5: sweep both wiper bytes over every value
        for (int v = 0; v < 256; v++) begin
            wr(8'hF8, 8'(v), "R4 sweep");
            wr(8'hF9, 8'(255 - v), "R5 sweep");
        end
        rd(8'hF9, "R5 full byte");

        // R9: reserved writes refused, nothing changes
        for (int a = 8'hFB; a < 256; a++) begin
            wr(8'(a), 8'hA5, "R9 rsvd");
            rd(8'(a), "R9 rsvd");
        end
        rd(8'hFA, "R9 lock untouched");

        // R6 and R7: every combination of the two lower lock bits
        for (int lk = 0; lk < 4; lk++) begin
            wr(8'hFA, 8'(8'hF8 | lk), "R6 set lock");
            rd(8'hFA, "R6 lock bits");
            wr(8'h00, 8'(8'h10 + lk), "R7 low");
            wr(8'h7F, 8'(8'h20 + lk), "R7 low top");
            wr(8'h80, 8'(8'h30 + lk), "R7 high");
            wr(8'hF7, 8'(8'h40 + lk), "R7 high top");
            wr(8'hF8, 8'(8'h50 + lk), "R7 wiper_a open");
            rd(8'h00, "R7 low");
            rd(8'h7F, "R7 low top");
            rd(8'h80, "R7 high");
            rd(8'hF7, "R7 high top");
        end

        // R8: top lock freezes wipers and locks
        wr(8'hFA, 8'h05, "R8 set top");
        wr(8'hF8, 8'h11, "R8 wiper_a");
        wr(8'hF9, 8'h22, "R8 wiper_b");
        wr(8'hFA, 8'h00, "R8 unlock try");
        rd(8'hFA, "R8 frozen lock");
        wr(8'h80, 8'h77, "R8 high open");
        wr(8'h10, 8'h66, "R8 low held");
        rd(8'h80, "R8 high");
        rd(8'h10, "R8 low");
        rd(8'hF8, "R8 wiper_a byte");

        // R1: reset clears locks and contents again
        do_reset();
        check("R1 wiper_a again", wiper_a, 0);
        check("R1 wiper_b again", wiper_b, 0);
        rd(8'hFA, "R1 lock clear");
        rd(8'h80, "R1 byte clear");
        wr(8'h10, 8'h99, "R1 writable");
        rd(8'h10, "R1 writable");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule